// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit processor core. Each source has its own pending latch. A per-source enable register and a single master enable decide which pending sources may raise a request. When the core signals that an instruction has retired, the block takes the lowest-numbered source that is both enabled and pending and acknowledges it. The acknowledge clears the master enable, clears that source's pending latch and presents a vector address for the core's automatic call.

The core drives three commands. `dis_cmd` clears the master enable and `en_cmd` sets it. `reti_cmd` (return from interrupt) also sets it. A handler may issue `en_cmd` itself, so interrupts can nest. The status outputs show the master enable and a sense flag. The sense flag is high whenever an enabled source is pending, even while the master enable is off.

The per-source enables are written through a byte-wide port. Only the low `NUM_SRC` bits of that byte are implemented. The bits above them read as zero and ignore writes.

Top module: `vic_top`

## Requirements
- R1: After reset (`rst_n` low at a clock edge), the master enable, every per-source enable and every pending latch are 0. As a result `irq_req` is 0 and `ack_valid` stays 0.
- R2: A 1 on `src_evt[i]` sets pending latch i on the next edge. The latch stays set until source i is acknowledged or reset occurs. Setting the latch has no effect on other sources.
- R3: `irq_req` is 1 exactly when some source has its pending latch, its enable bit and the master enable all at 1.
- R4: An acknowledge happens only in a cycle where `insn_done` is 1 and `irq_req` is 1. No acknowledge happens when `insn_done` is 0.
- R5: During an acknowledge, `ack_valid` is 1 for one cycle (registered, on the edge after the acknowledge cycle). At that edge the master enable reads 0 and the chosen pending latch is clear.
- R6: Priority is fixed. Among the enabled pending sources, the lowest index wins.
- R7: `ack_vector` equals `VEC_BASE + 2*index`. With the default parameters this is 0x0010 + 2*i.
- R8: `dis_cmd` clears the master enable. `en_cmd` and `reti_cmd` set it. These commands do not change the pending latches or the enable bits. If `dis_cmd` and `en_cmd` arrive together, `dis_cmd` wins.
- R9: `stat_sense` is 1 whenever any enabled source is pending, regardless of the master enable. `stat_gie` mirrors the master enable.
- R10: Writing `ien_wdata` with `ien_we` updates bits [NUM_SRC-1:0] of the enable register. `ien_rdata` returns those bits, and the upper bits read 0 even after a write of 1s.
- R11: If a source event arrives in the cycle its latch is cleared by an acknowledge, the latch remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | One-cycle event per source |
| insn_done | input | 1 | Instruction boundary reached |
| dis_cmd | input | 1 | Clear master enable |
| en_cmd | input | 1 | Set master enable |
| reti_cmd | input | 1 | Return from interrupt, sets master enable |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | REG_W | Enable register write data |
| ien_rdata | output | REG_W | Enable register readback |
| irq_req | output | 1 | Enabled request to core |
| ack_valid | output | 1 | Acknowledge pulse (call now) |
| ack_vector | output | VEC_W | Call target address |
| stat_gie | output | 1 | Master enable state |
| stat_sense | output | 1 | Enabled pending source present |

## Verification
The assertions assume that the core raises `insn_done` only in cycles where it can accept a call. They also assume that `reti_cmd` and the enable commands are never issued in the same cycle as an acknowledge. The directed stimulus keeps to both assumptions. It also applies all commands on cycles that are separate from the acknowledge cycles. The only exception is the deliberate collision test, which checks that a source event and an acknowledge of the same source can land on the same edge.

// File: rtl/vic_pkg.sv
// Package: shared parameters for the interrupt controller.
// Assumes: source count stays within the 8-bit enable register.
package vic_pkg;
    localparam int unsigned DEF_NUM_SRC = 5;
    localparam int unsigned DEF_REG_W   = 8;
    localparam int unsigned DEF_VEC_W   = 16;
endpackage

// File: rtl/vic_pending.sv
// Module: per-source pending latches.
// Sets on an event, clears on a targeted acknowledge; a simultaneous
// event wins so no event is lost. Assumes clr is one-hot or zero.
module vic_pending #(
    parameter int unsigned NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_latch
        // One latch per source, set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)          pend[g] <= 1'b0;
            else if (evt[g])     pend[g] <= 1'b1;
            else if (clr[g])     pend[g] <= 1'b0;
        end
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)); // R5
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt))); // R11
endmodule

// File: rtl/vic_prio.sv
// Module: fixed-priority picker and vector generator.
// Lowest index wins. Purely combinational.
module vic_prio #(
    parameter int unsigned NUM_SRC  = 5,
    parameter int unsigned VEC_W    = 16,
    parameter logic [15:0] VEC_BASE = 16'h0010
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic [VEC_W-1:0]   vector
);
    // Scan from the top so the lowest index is chosen last
    always_comb begin
        grant  = '0;
        vector = VEC_W'(VEC_BASE);
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                vector = VEC_W'(VEC_BASE) + VEC_W'(2 * i);
            end
        end
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R6
        AST_GRANT_IN_REQ: assert ((grant & ~req) == '0); // R6
    end
endmodule

// File: rtl/vic_top.sv
// Module: prioritized vectored interrupt controller top.
// Holds master enable and per-source enables, arbitrates at instruction
// boundaries and emits a registered acknowledge with vector.
// Assumes: commands do not coincide with an acknowledge cycle.
module vic_top #(
    parameter int unsigned NUM_SRC  = vic_pkg::DEF_NUM_SRC,
    parameter int unsigned REG_W    = vic_pkg::DEF_REG_W,
    parameter int unsigned VEC_W    = vic_pkg::DEF_VEC_W,
    parameter logic [15:0] VEC_BASE = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               insn_done,
    input  logic               dis_cmd,
    input  logic               en_cmd,
    input  logic               reti_cmd,
    input  logic               ien_we,
    input  logic [REG_W-1:0]   ien_wdata,
    output logic [REG_W-1:0]   ien_rdata,
    output logic               irq_req,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vector,
    output logic               stat_gie,
    output logic               stat_sense
);
    localparam int unsigned PAD_W = REG_W - NUM_SRC;

    logic               gie;
    logic [NUM_SRC-1:0] ien;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr;
    logic [VEC_W-1:0]   vec_c;
    logic               take;

    vic_pending #(.NUM_SRC(NUM_SRC)) i_pend (
        .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr(clr), .pend(pend)
    );

    vic_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_prio (
        .req(live), .grant(grant), .vector(vec_c)
    );

    // Enabled pending sources and acknowledge decision
    always_comb begin
        live    = pend & ien;
        irq_req = gie && (live != '0);
        take    = insn_done && irq_req;
        clr     = take ? grant : '0;
    end

    // Per-source enable register, reserved bits not stored
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (ien_we) ien <= ien_wdata[NUM_SRC-1:0];
    end

    // Master enable: acknowledge and disable clear, enable/return set
    always_ff @(posedge clk) begin
        if (!rst_n)                  gie <= 1'b0;
        else if (take || dis_cmd)    gie <= 1'b0;
        else if (en_cmd || reti_cmd) gie <= 1'b1;
    end

    // Registered acknowledge pulse and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid  <= take;
            if (take) ack_vector <= vec_c;
        end
    end

    assign ien_rdata  = {{PAD_W{1'b0}}, ien};
    assign stat_gie   = gie;
    assign stat_sense = (live != '0);

    AST_ACK_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(insn_done)); // R4
    AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> !stat_gie); // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R5
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> stat_gie && stat_sense); // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ien_rdata[REG_W-1:NUM_SRC] == '0); // R10
    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> !stat_gie); // R8
endmodule

// File: tb/test_vic_top.sv
// Directed bench for the interrupt controller.
module test_vic_top;
    localparam int N = 5;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_evt = '0;
    logic insn_done = 0, dis_cmd = 0, en_cmd = 0, reti_cmd = 0, ien_we = 0;
    logic [7:0] ien_wdata = '0;
    logic [7:0] ien_rdata;
    logic irq_req, ack_valid, stat_gie, stat_sense;
    logic [15:0] ack_vector;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    vic_top i_vic_top (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .insn_done(insn_done),
        .dis_cmd(dis_cmd), .en_cmd(en_cmd), .reti_cmd(reti_cmd),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_rdata(ien_rdata),
        .irq_req(irq_req), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .stat_gie(stat_gie), .stat_sense(stat_sense)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change just after the edge, samples mid-cycle
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0; src_evt = '0; insn_done = 0; dis_cmd = 0; en_cmd = 0;
        reti_cmd = 0; ien_we = 0; step(); step(); rst_n = 1;
    endtask

    task automatic wr_ien(input logic [7:0] v);
        ien_we = 1; ien_wdata = v; step(); ien_we = 0;
    endtask

    task automatic pulse_evt(input logic [N-1:0] v);
        src_evt = v; step(); src_evt = '0;
    endtask

    task automatic cmd_en();  en_cmd = 1; step(); en_cmd = 0; endtask

    // Boundary pulse, then return the vector seen on ack
    task automatic boundary(output logic got, output logic [15:0] vec);
        insn_done = 1; step(); insn_done = 0;
        got = ack_valid; vec = ack_vector;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 gie", 16'(stat_gie), 0);
        chk("R1 ien", 16'(ien_rdata), 0);
        chk("R1 req", 16'(irq_req), 0);
        chk("R1 sense", 16'(stat_sense), 0);
    endtask

    task automatic t_gating();
        logic got; logic [15:0] v;
        do_reset();
        pulse_evt(5'b00100);
        chk("R2 disabled pend no sense", 16'(stat_sense), 0);
        wr_ien(8'h04);
        chk("R9 sense with gie off", 16'(stat_sense), 1);
        chk("R3 req low gie off", 16'(irq_req), 0);
        boundary(got, v);
        chk("R4 no ack gie off", 16'(got), 0);
        cmd_en();
        chk("R3 req high", 16'(irq_req), 1);
        chk("R9 gie mirror", 16'(stat_gie), 1);
        step(); step();
        chk("R4 no ack without boundary", 16'(ack_valid), 0);
        boundary(got, v);
        chk("R5 ack", 16'(got), 1);
        chk("R7 vector src2", v, 16'h0014);
        chk("R5 gie cleared", 16'(stat_gie), 0);
        chk("R5 pend cleared", 16'(stat_sense), 0);
        step();
        chk("R5 one pulse", 16'(ack_valid), 0);
    endtask

    task automatic t_priority();
        logic got; logic [15:0] v;
        do_reset();
        wr_ien(8'h1F);
        pulse_evt(5'b11010);
        cmd_en();
        boundary(got, v);
        chk("R6 lowest first src1", v, 16'h0012);
        reti_cmd = 1; step(); reti_cmd = 0;
        chk("R8 reti sets gie", 16'(stat_gie), 1);
        boundary(got, v);
        chk("R6 next src3", v, 16'h0016);
        cmd_en();
        boundary(got, v);
        chk("R7 src4 vector", v, 16'h0018);
        chk("R2 all served", 16'(stat_sense), 0);
    endtask

    task automatic t_cmds();
        do_reset();
        wr_ien(8'h01);
        pulse_evt(5'b00001);
        cmd_en();
        dis_cmd = 1; en_cmd = 1; step(); dis_cmd = 0; en_cmd = 0;
        chk("R8 dis wins", 16'(stat_gie), 0);
        chk("R8 pend kept", 16'(stat_sense), 1);
        chk("R8 ien kept", 16'(ien_rdata), 16'h01);
        wr_ien(8'hFF);
        chk("R10 reserved read 0", 16'(ien_rdata), 16'h1F);
        wr_ien(8'hE0);
        chk("R10 reserved ignored", 16'(ien_rdata), 0);
        chk("R10 sense follows ien", 16'(stat_sense), 0);
    endtask

    task automatic t_collide();
        logic got; logic [15:0] v;
        do_reset();
        wr_ien(8'h01);
        pulse_evt(5'b00001);
        cmd_en();
        insn_done = 1; src_evt = 5'b00001; step();
        insn_done = 0; src_evt = '0;
        chk("R11 ack taken", 16'(ack_valid), 1);
        chk("R11 latch kept", 16'(stat_sense), 1);
        cmd_en();
        boundary(got, v);
        chk("R11 second ack", 16'(got), 1);
        chk("R7 src0 vector", v, 16'h0010);
    endtask

    initial begin
        #1;
        t_reset();
        t_gating();
        t_priority();
        t_cmds();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule